// File: doc/BRIEF.md
# Multi-Master AXI ID Widening and Response Steering Stage

This block sits between several independently designed AXI masters and one slave. On the read-address and write-address channels it arbitrates among the masters and forwards the winner. It widens the winner's transaction ID by placing the master's port index above the master's own ID bits. Two masters can therefore reuse the same raw ID values without the slave ever seeing a collision.

On the read-data and write-response channels the slave reflects the widened ID. The block reads the port index held in the upper ID bits and presents the beat only to that master. The upper bits are dropped on the way, so the master sees the ID it issued. Masters need no configuration and no awareness of the translation.

Address attributes and response payloads pass through untouched. A reflected ID whose port field names no existing master is absorbed: the slave-side handshake completes, no master sees the beat, and a sticky error flag is raised.

Top module: `axi_id_expander`

## Requirements
- R1: The slave-side ID has PFX_W + MID_W bits, where PFX_W is the bits needed to encode NUM_M ports. On every accepted AR or AW transfer, the upper PFX_W bits equal the index of the master whose ready was high, and the lower MID_W bits equal that master's raw ID. With NUM_M=3 and MID_W=4, raw ID 0x1 from ports 0, 1 and 2 becomes 0x01, 0x11 and 0x21.
- R2: Equal raw IDs issued by different masters reach the slave as different widened IDs.
- R3: The address attribute vector of the granted master reaches the slave bit for bit.
- R4: Each address channel arbitrates round-robin on its own. After reset, port 0 has first priority. After port k is accepted, the search starts at port k+1 and wraps past NUM_M-1 to 0.
- R5: While the slave-side address valid is high and ready is low, valid stays high and the ID and attributes stay unchanged on the next cycle.
- R6: A read-data or write-response beat is offered only to the master whose index equals the ID's upper field. At most one master valid is high at a time.
- R7: The ID delivered to a master equals the lower MID_W bits of the reflected ID.
- R8: Slave-side RREADY or BREADY equals the ready of the selected master. Read data, read response, RLAST and write response are forwarded unchanged.
- R9: A reflected ID whose upper field is NUM_M or more is accepted at once, with ready high. No master sees it. prefix_err rises on the following cycle and stays high until reset.
- R10: After reset, no slave-side address valid and no master-side response valid is high, and prefix_err is low.
- R11: Each master receives exactly the responses to its own requests. For each raw ID, they arrive in issue order, even when the slave interleaves different widened IDs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_ar_valid | input | NUM_M | Read-address valid per master |
| m_ar_ready | output | NUM_M | Read-address ready per master |
| m_ar_id | input | NUM_M*MID_W | Raw read IDs, master i at bits i*MID_W |
| m_ar_attr | input | NUM_M*ATTR_W | Read address and attributes per master |
| s_ar_valid | output | 1 | Read-address valid to slave |
| s_ar_ready | input | 1 | Read-address ready from slave |
| s_ar_id | output | SID_W | Widened read ID |
| s_ar_attr | output | ATTR_W | Read address and attributes to slave |
| m_aw_valid | input | NUM_M | Write-address valid per master |
| m_aw_ready | output | NUM_M | Write-address ready per master |
| m_aw_id | input | NUM_M*MID_W | Raw write IDs |
| m_aw_attr | input | NUM_M*ATTR_W | Write address and attributes per master |
| s_aw_valid | output | 1 | Write-address valid to slave |
| s_aw_ready | input | 1 | Write-address ready from slave |
| s_aw_id | output | SID_W | Widened write ID |
| s_aw_attr | output | ATTR_W | Write address and attributes to slave |
| s_r_valid | input | 1 | Read-data valid from slave |
| s_r_ready | output | 1 | Read-data ready to slave |
| s_r_id | input | SID_W | Reflected read ID |
| s_r_data | input | DATA_W | Read data |
| s_r_resp | input | RESP_W | Read response |
| s_r_last | input | 1 | Last beat of burst |
| m_r_valid | output | NUM_M | Read-data valid per master |
| m_r_ready | input | NUM_M | Read-data ready per master |
| m_r_id | output | NUM_M*MID_W | Restored read ID per master |
| m_r_data | output | NUM_M*DATA_W | Read data per master |
| m_r_resp | output | NUM_M*RESP_W | Read response per master |
| m_r_last | output | NUM_M | Last flag per master |
| s_b_valid | input | 1 | Write-response valid from slave |
| s_b_ready | output | 1 | Write-response ready to slave |
| s_b_id | input | SID_W | Reflected write ID |
| s_b_resp | input | RESP_W | Write response |
| m_b_valid | output | NUM_M | Write-response valid per master |
| m_b_ready | input | NUM_M | Write-response ready per master |
| m_b_id | output | NUM_M*MID_W | Restored write ID per master |
| m_b_resp | output | NUM_M*RESP_W | Write response per master |
| prefix_err | output | 1 | Sticky flag: a response named no existing port |

## Verification
The hardest case to reach is a collision the block must disentangle. All masters use the same small set of raw IDs at once. The slave returns the widened IDs out of order while masters apply backpressure at random. A stuck prefix bit or a swapped ready then shows up as a response at the wrong master, or as an out-of-order beat for one raw ID.

To get there, three master threads issue requests with raw IDs drawn from {0,1}, and the slave accepts them with random stalls. A slave model picks any pending request to answer next, but only the oldest of its widened ID. A per-master scoreboard pairs each delivered beat with the first outstanding request of the same raw ID. Directed rounds cover the reset-time priority, the wrap-around of the grant, a stalled slave, and an ID field naming the unused fourth port.

// File: rtl/axi_idx_pkg.sv
// Package axi_idx_pkg
// Shared helpers for the ID widening stage.
// Assumes: port counts are at least 1.
package axi_idx_pkg;

    // Bits needed to encode a port index; at least one bit.
    function automatic int pfx_bits(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/idx_rr_arb.sv
// Module idx_rr_arb
// Round-robin arbiter whose grant is frozen while the downstream transfer waits.
// Assumes requesters keep req high until served (AXI valid rule).
module idx_rr_arb #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          dn_ready,
    output logic          dn_valid,
    output logic [IW-1:0] gnt_idx,
    output logic [N-1:0]  gnt_oh
);

    logic          locked;
    logic [IW-1:0] lock_idx;
    logic [IW-1:0] last_idx;
    logic [IW-1:0] pick;
    logic          found;

    // Search for the next requester after the last one served.
    always_comb begin
        pick  = last_idx;
        found = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (int'(last_idx) + k) % N;
            if (!found && req[c]) begin
                found = 1'b1;
                pick  = IW'(c);
            end
        end
    end

    assign gnt_idx  = locked ? lock_idx : pick;
    assign dn_valid = locked | found;

    // Decode the chosen index into a one-hot grant.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            gnt_oh[i] = dn_valid && (gnt_idx == IW'(i));
        end
    end

    // Track the held grant and the last port served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked   <= 1'b0;
            lock_idx <= '0;
            last_idx <= IW'(N - 1);
        end else if (dn_valid && dn_ready) begin
            locked   <= 1'b0;
            last_idx <= gnt_idx;
        end else if (dn_valid) begin
            locked   <= 1'b1;
            lock_idx <= gnt_idx;
        end
    end

    a_r4_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_oh));

    a_r5_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ready |=> dn_valid && (gnt_idx == $past(gnt_idx)));

endmodule

// File: rtl/idx_req_path.sv
// Module idx_req_path
// One address channel: arbitrates masters, widens the winner's ID with its port index.
// Assumes masters hold id and attributes stable while valid is high.
module idx_req_path #(
    parameter int N      = 3,
    parameter int MID_W  = 4,
    parameter int ATTR_W = 40,
    parameter int PFX_W  = 2,
    localparam int SID_W = PFX_W + MID_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        m_valid,
    output logic [N-1:0]        m_ready,
    input  logic [N*MID_W-1:0]  m_id,
    input  logic [N*ATTR_W-1:0] m_attr,
    output logic                s_valid,
    input  logic                s_ready,
    output logic [SID_W-1:0]    s_id,
    output logic [ATTR_W-1:0]   s_attr
);

    logic [PFX_W-1:0] gnt_idx;
    logic [N-1:0]     gnt_oh;
    logic [MID_W-1:0] raw_id;

    idx_rr_arb #(.N(N), .IW(PFX_W)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (m_valid),
        .dn_ready(s_ready),
        .dn_valid(s_valid),
        .gnt_idx (gnt_idx),
        .gnt_oh  (gnt_oh)
    );

    // One-hot mux of the granted master's ID and attributes.
    always_comb begin
        raw_id = '0;
        s_attr = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt_oh[i]) begin
                raw_id = raw_id | m_id[i*MID_W +: MID_W];
                s_attr = s_attr | m_attr[i*ATTR_W +: ATTR_W];
            end
        end
    end

    assign s_id    = {gnt_idx, raw_id};
    assign m_ready = gnt_oh & {N{s_ready}};

    a_r5_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid && !s_ready |=> s_valid && $stable(s_id) && $stable(s_attr));

    generate
        for (genvar g = 0; g < N; g++) begin : g_chk
            a_r1_prefix_is_port: assert property (@(posedge clk) disable iff (!rst_n)
                m_ready[g] |-> (s_id[SID_W-1 -: PFX_W] == PFX_W'(g))
                               && (s_id[MID_W-1:0] == m_id[g*MID_W +: MID_W]));
        end
    endgenerate

endmodule

// File: rtl/idx_rsp_path.sv
// Module idx_rsp_path
// One response channel: steers a beat by the ID's port field and strips that field.
// Assumes the slave reflects the widened ID unchanged.
module idx_rsp_path #(
    parameter int N     = 3,
    parameter int MID_W = 4,
    parameter int PFX_W = 2,
    parameter int PAY_W = 35,
    localparam int SID_W = PFX_W + MID_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s_valid,
    output logic               s_ready,
    input  logic [SID_W-1:0]   s_id,
    input  logic [PAY_W-1:0]   s_pay,
    output logic [N-1:0]       m_valid,
    input  logic [N-1:0]       m_ready,
    output logic [N*MID_W-1:0] m_id,
    output logic [N*PAY_W-1:0] m_pay,
    output logic               bad_seen
);

    logic [PFX_W-1:0] pfx;
    logic             hit;
    logic             sel_ready;

    assign pfx = s_id[SID_W-1 -: PFX_W];
    assign hit = (int'(pfx) < N);

    // Select the target master and its ready.
    always_comb begin
        sel_ready = 1'b0;
        for (int i = 0; i < N; i++) begin
            m_valid[i] = s_valid && hit && (pfx == PFX_W'(i));
            if (pfx == PFX_W'(i)) sel_ready = m_ready[i];
        end
    end

    assign s_ready = hit ? sel_ready : 1'b1;

    generate
        for (genvar g = 0; g < N; g++) begin : g_fan
            assign m_id[g*MID_W +: MID_W]  = s_id[MID_W-1:0];
            assign m_pay[g*PAY_W +: PAY_W] = s_pay;

            a_r8_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
                m_valid[g] |-> (s_ready == m_ready[g]));
        end
    endgenerate

    // Remember any beat that named a port that does not exist.
    always_ff @(posedge clk) begin
        if (!rst_n) bad_seen <= 1'b0;
        else if (s_valid && !hit) bad_seen <= 1'b1;
    end

    a_r6_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_valid));

    a_r9_bad_absorbed: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid && (int'(s_id[SID_W-1 -: PFX_W]) >= N) |-> s_ready && (m_valid == '0));

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        bad_seen |=> bad_seen);

endmodule

// File: rtl/axi_id_expander.sv
// Module axi_id_expander
// N masters to one slave: widens AR/AW IDs with the port index, steers R/B back by it.
// Assumes the slave reflects IDs unchanged; write data is handled elsewhere.
module axi_id_expander
    import axi_idx_pkg::*;
#(
    parameter int NUM_M  = 3,
    parameter int MID_W  = 4,
    parameter int ATTR_W = 40,
    parameter int DATA_W = 32,
    parameter int RESP_W = 2,
    localparam int PFX_W = pfx_bits(NUM_M),
    localparam int SID_W = PFX_W + MID_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_M-1:0]         m_ar_valid,
    output logic [NUM_M-1:0]         m_ar_ready,
    input  logic [NUM_M*MID_W-1:0]   m_ar_id,
    input  logic [NUM_M*ATTR_W-1:0]  m_ar_attr,
    output logic                     s_ar_valid,
    input  logic                     s_ar_ready,
    output logic [SID_W-1:0]         s_ar_id,
    output logic [ATTR_W-1:0]        s_ar_attr,
    input  logic [NUM_M-1:0]         m_aw_valid,
    output logic [NUM_M-1:0]         m_aw_ready,
    input  logic [NUM_M*MID_W-1:0]   m_aw_id,
    input  logic [NUM_M*ATTR_W-1:0]  m_aw_attr,
    output logic                     s_aw_valid,
    input  logic                     s_aw_ready,
    output logic [SID_W-1:0]         s_aw_id,
    output logic [ATTR_W-1:0]        s_aw_attr,
    input  logic                     s_r_valid,
    output logic                     s_r_ready,
    input  logic [SID_W-1:0]         s_r_id,
    input  logic [DATA_W-1:0]        s_r_data,
    input  logic [RESP_W-1:0]        s_r_resp,
    input  logic                     s_r_last,
    output logic [NUM_M-1:0]         m_r_valid,
    input  logic [NUM_M-1:0]         m_r_ready,
    output logic [NUM_M*MID_W-1:0]   m_r_id,
    output logic [NUM_M*DATA_W-1:0]  m_r_data,
    output logic [NUM_M*RESP_W-1:0]  m_r_resp,
    output logic [NUM_M-1:0]         m_r_last,
    input  logic                     s_b_valid,
    output logic                     s_b_ready,
    input  logic [SID_W-1:0]         s_b_id,
    input  logic [RESP_W-1:0]        s_b_resp,
    output logic [NUM_M-1:0]         m_b_valid,
    input  logic [NUM_M-1:0]         m_b_ready,
    output logic [NUM_M*MID_W-1:0]   m_b_id,
    output logic [NUM_M*RESP_W-1:0]  m_b_resp,
    output logic                     prefix_err
);

    localparam int RPAY_W = DATA_W + RESP_W + 1;

    logic [NUM_M*RPAY_W-1:0] r_pay;
    logic                    r_bad;
    logic                    b_bad;

    idx_req_path #(.N(NUM_M), .MID_W(MID_W), .ATTR_W(ATTR_W), .PFX_W(PFX_W)) u_ar (
        .clk(clk), .rst_n(rst_n),
        .m_valid(m_ar_valid), .m_ready(m_ar_ready), .m_id(m_ar_id), .m_attr(m_ar_attr),
        .s_valid(s_ar_valid), .s_ready(s_ar_ready), .s_id(s_ar_id), .s_attr(s_ar_attr)
    );

    idx_req_path #(.N(NUM_M), .MID_W(MID_W), .ATTR_W(ATTR_W), .PFX_W(PFX_W)) u_aw (
        .clk(clk), .rst_n(rst_n),
        .m_valid(m_aw_valid), .m_ready(m_aw_ready), .m_id(m_aw_id), .m_attr(m_aw_attr),
        .s_valid(s_aw_valid), .s_ready(s_aw_ready), .s_id(s_aw_id), .s_attr(s_aw_attr)
    );

    idx_rsp_path #(.N(NUM_M), .MID_W(MID_W), .PFX_W(PFX_W), .PAY_W(RPAY_W)) u_r (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_r_valid), .s_ready(s_r_ready), .s_id(s_r_id),
        .s_pay({s_r_data, s_r_resp, s_r_last}),
        .m_valid(m_r_valid), .m_ready(m_r_ready), .m_id(m_r_id), .m_pay(r_pay),
        .bad_seen(r_bad)
    );

    idx_rsp_path #(.N(NUM_M), .MID_W(MID_W), .PFX_W(PFX_W), .PAY_W(RESP_W)) u_b (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_b_valid), .s_ready(s_b_ready), .s_id(s_b_id), .s_pay(s_b_resp),
        .m_valid(m_b_valid), .m_ready(m_b_ready), .m_id(m_b_id), .m_pay(m_b_resp),
        .bad_seen(b_bad)
    );

    // Unpack the read payload per master.
    generate
        for (genvar g = 0; g < NUM_M; g++) begin : g_rpay
            assign m_r_data[g*DATA_W +: DATA_W] = r_pay[g*RPAY_W + RESP_W + 1 +: DATA_W];
            assign m_r_resp[g*RESP_W +: RESP_W] = r_pay[g*RPAY_W + 1 +: RESP_W];
            assign m_r_last[g]                  = r_pay[g*RPAY_W];
        end
    endgenerate

    assign prefix_err = r_bad | b_bad;

    a_r10_reset_quiet: assert property (@(posedge clk)
        $past(!rst_n) && !rst_n |-> !prefix_err && !s_ar_valid || (m_ar_valid != '0));

endmodule

// File: tb/axi_id_expander_tb.sv
module axi_id_expander_tb;

    localparam int N  = 3;
    localparam int MW = 4;
    localparam int AT = 40;
    localparam int DW = 32;
    localparam int SW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [N-1:0]    m_ar_valid = '0, m_ar_ready, m_aw_valid = '0, m_aw_ready;
    logic [N*MW-1:0] m_ar_id = '0, m_aw_id = '0, m_r_id, m_b_id;
    logic [N*AT-1:0] m_ar_attr = '0, m_aw_attr = '0;
    logic            s_ar_valid, s_aw_valid, s_ar_ready = 1'b0, s_aw_ready = 1'b0;
    logic [SW-1:0]   s_ar_id, s_aw_id, s_r_id = '0, s_b_id = '0;
    logic [AT-1:0]   s_ar_attr, s_aw_attr;
    logic            s_r_valid = 1'b0, s_r_ready, s_r_last = 1'b0;
    logic [DW-1:0]   s_r_data = '0;
    logic [1:0]      s_r_resp = '0, s_b_resp = '0;
    logic [N-1:0]    m_r_valid, m_r_ready = '0, m_r_last, m_b_valid, m_b_ready = '0;
    logic [N*DW-1:0] m_r_data;
    logic [N*2-1:0]  m_r_resp, m_b_resp;
    logic            s_b_valid = 1'b0, s_b_ready, prefix_err;

    axi_id_expander u_dut (
        .clk(clk), .rst_n(rst_n),
        .m_ar_valid(m_ar_valid), .m_ar_ready(m_ar_ready), .m_ar_id(m_ar_id), .m_ar_attr(m_ar_attr),
        .s_ar_valid(s_ar_valid), .s_ar_ready(s_ar_ready), .s_ar_id(s_ar_id), .s_ar_attr(s_ar_attr),
        .m_aw_valid(m_aw_valid), .m_aw_ready(m_aw_ready), .m_aw_id(m_aw_id), .m_aw_attr(m_aw_attr),
        .s_aw_valid(s_aw_valid), .s_aw_ready(s_aw_ready), .s_aw_id(s_aw_id), .s_aw_attr(s_aw_attr),
        .s_r_valid(s_r_valid), .s_r_ready(s_r_ready), .s_r_id(s_r_id), .s_r_data(s_r_data),
        .s_r_resp(s_r_resp), .s_r_last(s_r_last),
        .m_r_valid(m_r_valid), .m_r_ready(m_r_ready), .m_r_id(m_r_id), .m_r_data(m_r_data),
        .m_r_resp(m_r_resp), .m_r_last(m_r_last),
        .s_b_valid(s_b_valid), .s_b_ready(s_b_ready), .s_b_id(s_b_id), .s_b_resp(s_b_resp),
        .m_b_valid(m_b_valid), .m_b_ready(m_b_ready), .m_b_id(m_b_id), .m_b_resp(m_b_resp),
        .prefix_err(prefix_err)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // Scoreboards: expected per master {raw id, last, data} and {raw id, resp}.
    logic [36:0] exp_r [N][$];
    logic [5:0]  exp_b [N][$];
    // Slave model pending responses: {sid, last, data} and {sid, resp}.
    logic [38:0] pend_r [$];
    logic [7:0]  pend_b [$];
    int ar_order [$];
    int aw_order [$];

    bit bg_en = 1'b1;
    bit rnd_ready = 1'b0;
    bit r_hs = 1'b0;
    bit b_hs = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_addr(input int p, input int rid, input int seq);
        return {16'hA000, 4'(p), 4'(rid), 8'(seq)};
    endfunction

    // Driver: issue one read request from master p and record the expected response.
    task automatic drive_ar(input int p, input int rid, input int seq);
        logic [31:0] a;
        a = mk_addr(p, rid, seq);
        @(posedge clk); #1;
        m_ar_id[p*MW +: MW]   = 4'(rid);
        m_ar_attr[p*AT +: AT] = {a[7:0] ^ 8'h5A, a};
        m_ar_valid[p] = 1'b1;
        forever begin
            @(negedge clk);
            if (m_ar_ready[p]) break;
        end
        exp_r[p].push_back({4'(rid), a[0], a ^ 32'h5555_0000});
        @(posedge clk); #1;
        m_ar_valid[p] = 1'b0;
    endtask

    // Driver: issue one write-address request from master p.
    task automatic drive_aw(input int p, input int rid, input int seq);
        logic [31:0] a;
        a = mk_addr(p, rid, seq);
        @(posedge clk); #1;
        m_aw_id[p*MW +: MW]   = 4'(rid);
        m_aw_attr[p*AT +: AT] = {a[7:0] ^ 8'hC3, a};
        m_aw_valid[p] = 1'b1;
        forever begin
            @(negedge clk);
            if (m_aw_ready[p]) break;
        end
        exp_b[p].push_back({4'(rid), a[1:0]});
        @(posedge clk); #1;
        m_aw_valid[p] = 1'b0;
    endtask

    task automatic master_thread(input int p);
        for (int k = 0; k < 12; k++) begin
            drive_ar(p, int'($urandom_range(1)), 16 + 2*k);
            drive_aw(p, int'($urandom_range(1)), 17 + 2*k);
        end
    endtask

    // Monitor: slave-side capture and master-side scoreboard, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (s_ar_valid && s_ar_ready) begin
                chk(s_ar_id == {2'(s_ar_attr[15:12]), s_ar_attr[11:8]}, "R1/R2 AR widened id",
                    64'(s_ar_id), 64'({2'(s_ar_attr[15:12]), s_ar_attr[11:8]}));
                chk(s_ar_attr[39:32] == (s_ar_attr[7:0] ^ 8'h5A), "R3 AR attr",
                    64'(s_ar_attr[39:32]), 64'(s_ar_attr[7:0] ^ 8'h5A));
                ar_order.push_back(int'(s_ar_id[5:4]));
                pend_r.push_back({s_ar_id, s_ar_attr[0], s_ar_attr[31:0] ^ 32'h5555_0000});
            end
            if (s_aw_valid && s_aw_ready) begin
                chk(s_aw_id == {2'(s_aw_attr[15:12]), s_aw_attr[11:8]}, "R1/R2 AW widened id",
                    64'(s_aw_id), 64'({2'(s_aw_attr[15:12]), s_aw_attr[11:8]}));
                chk(s_aw_attr[39:32] == (s_aw_attr[7:0] ^ 8'hC3), "R3 AW attr",
                    64'(s_aw_attr[39:32]), 64'(s_aw_attr[7:0] ^ 8'hC3));
                aw_order.push_back(int'(s_aw_id[5:4]));
                pend_b.push_back({s_aw_id, s_aw_attr[1:0]});
            end
            r_hs = s_r_valid && s_r_ready;
            b_hs = s_b_valid && s_b_ready;
            if (s_r_valid && bg_en) begin
                int p;
                p = int'(s_r_id[5:4]);
                chk(m_r_valid == 3'(1 << p), "R6 R routed to prefix port", 64'(m_r_valid), 64'(1 << p));
                chk(m_r_id[p*MW +: MW] == s_r_id[3:0], "R7 R id stripped",
                    64'(m_r_id[p*MW +: MW]), 64'(s_r_id[3:0]));
                chk(s_r_ready == m_r_ready[p] && m_r_last[p] == s_r_last
                    && m_r_data[p*DW +: DW] == s_r_data, "R8 R ready/last/data",
                    64'({s_r_ready, m_r_last[p]}), 64'({m_r_ready[p], s_r_last}));
            end
            if (s_b_valid && bg_en) begin
                int p;
                p = int'(s_b_id[5:4]);
                chk(m_b_valid == 3'(1 << p), "R6 B routed to prefix port", 64'(m_b_valid), 64'(1 << p));
                chk(s_b_ready == m_b_ready[p], "R8 B ready follows master",
                    64'(s_b_ready), 64'(m_b_ready[p]));
            end
            for (int p = 0; p < N; p++) begin
                if (m_r_valid[p] && m_r_ready[p]) begin
                    int k;
                    k = -1;
                    for (int j = 0; j < exp_r[p].size(); j++)
                        if (k < 0 && exp_r[p][j][36:33] == m_r_id[p*MW +: MW]) k = j;
                    if (k < 0) begin
                        chk(1'b0, "R11 R beat matches no own request", 64'(m_r_id[p*MW +: MW]), 64'(p));
                    end else begin
                        chk({m_r_last[p], m_r_data[p*DW +: DW]} == exp_r[p][k][32:0],
                            "R11 R own response in id order",
                            64'({m_r_last[p], m_r_data[p*DW +: DW]}), 64'(exp_r[p][k][32:0]));
                        exp_r[p].delete(k);
                    end
                end
                if (m_b_valid[p] && m_b_ready[p]) begin
                    int k;
                    k = -1;
                    for (int j = 0; j < exp_b[p].size(); j++)
                        if (k < 0 && exp_b[p][j][5:2] == m_b_id[p*MW +: MW]) k = j;
                    if (k < 0) begin
                        chk(1'b0, "R11 B beat matches no own request", 64'(m_b_id[p*MW +: MW]), 64'(p));
                    end else begin
                        chk(m_b_resp[p*2 +: 2] == exp_b[p][k][1:0], "R11 B own response in id order",
                            64'(m_b_resp[p*2 +: 2]), 64'(exp_b[p][k][1:0]));
                        exp_b[p].delete(k);
                    end
                end
            end
        end
    end

    // Slave R responder: random pick, oldest of the chosen widened id.
    initial begin
        forever begin
            @(posedge clk); #1;
            if (bg_en && (!s_r_valid || r_hs)) begin
                r_hs = 1'b0;
                if (pend_r.size() > 0) begin
                    int j, k;
                    j = int'($urandom_range(pend_r.size() - 1));
                    k = j;
                    for (int i = j; i >= 0; i--)
                        if (pend_r[i][38:33] == pend_r[j][38:33]) k = i;
                    s_r_valid = 1'b1;
                    s_r_id    = pend_r[k][38:33];
                    s_r_last  = pend_r[k][32];
                    s_r_data  = pend_r[k][31:0];
                    pend_r.delete(k);
                end else begin
                    s_r_valid = 1'b0;
                end
            end
        end
    end

    // Slave B responder: same ordering discipline.
    initial begin
        forever begin
            @(posedge clk); #1;
            if (bg_en && (!s_b_valid || b_hs)) begin
                b_hs = 1'b0;
                if (pend_b.size() > 0) begin
                    int j, k;
                    j = int'($urandom_range(pend_b.size() - 1));
                    k = j;
                    for (int i = j; i >= 0; i--)
                        if (pend_b[i][7:2] == pend_b[j][7:2]) k = i;
                    s_b_valid = 1'b1;
                    s_b_id    = pend_b[k][7:2];
                    s_b_resp  = pend_b[k][1:0];
                    pend_b.delete(k);
                end else begin
                    s_b_valid = 1'b0;
                end
            end
        end
    end

    // Random backpressure from masters and, when enabled, from the slave.
    initial begin
        forever begin
            @(posedge clk); #1;
            m_r_ready = 3'($urandom);
            m_b_ready = 3'($urandom);
            if (rnd_ready) begin
                s_ar_ready = 1'($urandom);
                s_aw_ready = 1'($urandom);
            end
        end
    end

    function automatic bit all_drained();
        bit e;
        e = (pend_r.size() == 0) && (pend_b.size() == 0) && !s_r_valid && !s_b_valid;
        for (int p = 0; p < N; p++) e = e && (exp_r[p].size() == 0) && (exp_b[p].size() == 0);
        return e;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: quiet after reset
        chk(!s_ar_valid && !s_aw_valid, "R10 no address valid", 64'({s_ar_valid, s_aw_valid}), 0);
        chk(m_r_valid == 0 && m_b_valid == 0, "R10 no response valid", 64'({m_r_valid, m_b_valid}), 0);
        chk(!prefix_err, "R10 prefix_err low", 64'(prefix_err), 0);

        // R1 R2 R4 R5: all masters issue raw id 1 against a stalled slave
        fork
            drive_ar(0, 1, 0);
            drive_ar(1, 1, 0);
            drive_ar(2, 1, 0);
        join_none
        @(posedge clk); #1;
        @(negedge clk);
        chk(s_ar_valid && s_ar_id == 6'h01, "R4 port 0 first after reset", 64'(s_ar_id), 64'h01);
        @(negedge clk);
        chk(s_ar_valid && s_ar_id == 6'h01 && s_ar_attr[31:0] == mk_addr(0, 1, 0),
            "R5 stalled request stable", 64'(s_ar_id), 64'h01);
        chk(m_ar_ready == 0, "R5 no ready while stalled", 64'(m_ar_ready), 0);
        @(posedge clk); #1 s_ar_ready = 1'b1;
        wait fork;
        @(posedge clk); #1 s_ar_ready = 1'b0;
        chk(ar_order.size() == 3 && ar_order[0] == 0 && ar_order[1] == 1 && ar_order[2] == 2,
            "R4 rotation 0,1,2", 64'(ar_order.size()), 3);

        // R4: AW arbiter independent; port 1 alone then ports 0 and 2 -> wrap order 2,0
        s_aw_ready = 1'b1;
        drive_aw(1, 1, 1);
        fork
            drive_aw(0, 1, 2);
            drive_aw(2, 1, 2);
        join
        chk(aw_order.size() == 3 && aw_order[1] == 2 && aw_order[2] == 0,
            "R4 wrap order 2 then 0", 64'(aw_order.size() > 2 ? aw_order[1] : -1), 2);
        s_aw_ready = 1'b0;

        // R11: colliding raw ids, random slave order and backpressure
        rnd_ready = 1'b1;
        fork
            master_thread(0);
            master_thread(1);
            master_thread(2);
        join
        rnd_ready = 1'b0;
        @(posedge clk); #1;
        s_ar_ready = 1'b0;
        s_aw_ready = 1'b0;
        while (!all_drained()) @(posedge clk);
        repeat (4) @(posedge clk);
        chk(all_drained(), "R11 every response delivered", 0, 0);

        // R9: response naming nonexistent port 3
        bg_en = 1'b0;
        @(posedge clk); #1;
        s_b_valid = 1'b1;
        s_b_id    = 6'h35;
        @(negedge clk);
        chk(m_b_valid == 0, "R9 bad prefix reaches no master", 64'(m_b_valid), 0);
        chk(s_b_ready, "R9 bad prefix accepted", 64'(s_b_ready), 1);
        chk(!prefix_err, "R9 flag not yet set", 64'(prefix_err), 0);
        @(posedge clk); #1 s_b_valid = 1'b0;
        @(negedge clk);
        chk(prefix_err, "R9 flag set", 64'(prefix_err), 1);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(prefix_err, "R9 flag sticky", 64'(prefix_err), 1);
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!prefix_err, "R10 flag cleared by reset", 64'(prefix_err), 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule